// File: doc/BRIEF.md
# Wiper Store/Restore Controller

This block owns the 6-bit position register of a 64-step digital potentiometer and keeps it consistent with one nonvolatile memory word. Reset models power-on. During and just after reset the position sits at midscale. Once a timed restore window has elapsed, the position takes the value held in the nonvolatile word.

A host drives single-cycle commands, each with an opcode and a data byte. The commands can set the position directly, save it to the nonvolatile word, reload it from that word, latch the word for read-back, and arm a software write-protect. Saves and reloads run inside timed busy windows. The nonvolatile write path is also locked for a rewrite interval after power-on. Write-protect disables only the save path; the host can still set the position directly while it is armed.

All window lengths are parameters counted in clock cycles. The memory itself lives outside the block and is reached through a read-data input and a one-cycle write strobe.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While reset is high, and for RESTORE_CYC-1 cycles after its release, `wiper` holds midscale 0x20 and `busy` is high. While reset is high, `nv_lock` is 1 and `wp`, `err` and `nv_we` are 0.
- R2: On the RESTORE_CYC-th clock edge after reset is released, `wiper` takes `nv_rd_data` and `busy` falls.
- R3: Opcode 1 (write) with `busy` low loads `cmd_data` into `wiper` at the next edge. This holds whether or not write-protect is armed.
- R4: Opcode 2 (store), when accepted, raises `nv_we` for exactly one cycle with `nv_wdata` equal to `wiper`. `busy` is then high for STORE_CYC cycles.
- R5: Opcode 3 (restore) holds `busy` high for RESTORE_CYC cycles. `wiper` is unchanged until the last edge of that window, where it takes `nv_rd_data`.
- R6: Opcode 4 arms write-protect (`wp`=1) until reset. While it is armed, a store raises `err` for one cycle and produces no `nv_we`.
- R7: `nv_lock` stays high for REWRITE_CYC cycles after reset release. A store inside that window is rejected with `err` and no `nv_we`.
- R8: Any command arriving while `busy` is high is rejected with a one-cycle `err` and leaves `wiper` unchanged.
- R9: Opcode 5 copies `nv_rd_data` into `nv_view` at the next edge.
- R10: Opcodes 6 and 7 are undefined. They raise `err` for one cycle and change no state. Opcode 0 does nothing and raises no `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, models power-on |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 6 | Position value for the write command |
| nv_rd_data | input | 6 | Current content of the nonvolatile word |
| wiper | output | 6 | Position register |
| busy | output | 1 | Store or restore window in progress |
| nv_lock | output | 1 | Post-power-on rewrite lockout active |
| wp | output | 1 | Write-protect armed |
| err | output | 1 | One-cycle pulse for a rejected command |
| nv_we | output | 1 | One-cycle write strobe to the nonvolatile word |
| nv_wdata | output | 6 | Data written with `nv_we` |
| nv_view | output | 6 | Latched read-back of the nonvolatile word |

## Verification
The assertions assume that the nonvolatile word does not change while a restore window is running. The memory is written only through `nv_we`, except when the stimulus preloads it. They also assume that a command is qualified only by `cmd_valid` and that a valid command lasts exactly one cycle. The bench drives every command for a single cycle on the falling edge. It preloads the memory model only during reset or while the block is idle, and never while a restore is underway.

// File: rtl/wnv_pkg.sv
package wnv_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WRITE   = 3'd1,
    OP_STORE   = 3'd2,
    OP_RESTORE = 3'd3,
    OP_SETWP   = 3'd4,
    OP_READNV  = 3'd5
  } op_e;

  // Code of the middle position for a register of the given width.
  function automatic int midscale(input int pos_w);
    return 1 << (pos_w - 1);
  endfunction

  // Opcodes above the last defined one are rejected.
  function automatic logic op_defined(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wnv_timer.sv
// Down-counting window: active for exactly load+1 edges after start.
module wnv_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_load,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         active,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cnt    <= rst_load;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= load;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  // Last cycle of the window, named for the assertions and the sequencer.
  assign done = active && (cnt == '0);

  p_window_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !active);

endmodule

// File: rtl/wnv_seq.sv
module wnv_seq
  import wnv_pkg::*;
#(
  parameter int POS_W       = 6,
  parameter int CNT_W       = 8,
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [POS_W-1:0] cmd_data,
  input  logic [POS_W-1:0] nv_rd_data,
  input  logic             op_busy,
  input  logic             op_done,
  input  logic             lock_active,
  output logic             op_start,
  output logic [CNT_W-1:0] op_load,
  output logic [POS_W-1:0] wiper,
  output logic             nv_we,
  output logic [POS_W-1:0] nv_wdata,
  output logic [POS_W-1:0] nv_view,
  output logic             wp,
  output logic             err
);

  localparam logic [POS_W-1:0] MID       = POS_W'(midscale(POS_W));
  localparam logic [CNT_W-1:0] STORE_LD  = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] RESTORE_LD = CNT_W'(RESTORE_CYC - 1);

  op_e  op;
  logic restoring;
  logic rej_busy, rej_store, rej_undef, reject;
  logic acc_write, acc_store, acc_restore, acc_wp, acc_read;

  assign op = op_e'(cmd_op);

  // Rejection causes, each a named event.
  assign rej_busy  = cmd_valid && op_busy;
  assign rej_undef = cmd_valid && !op_busy && !op_defined(cmd_op);
  assign rej_store = cmd_valid && !op_busy && (op == OP_STORE) && (wp || lock_active);
  assign reject    = rej_busy || rej_undef || rej_store;

  assign acc_write   = cmd_valid && !op_busy && (op == OP_WRITE);
  assign acc_store   = cmd_valid && !op_busy && (op == OP_STORE) && !wp && !lock_active;
  assign acc_restore = cmd_valid && !op_busy && (op == OP_RESTORE);
  assign acc_wp      = cmd_valid && !op_busy && (op == OP_SETWP);
  assign acc_read    = cmd_valid && !op_busy && (op == OP_READNV);

  assign op_start = acc_store || acc_restore;
  assign op_load  = acc_store ? STORE_LD : RESTORE_LD;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper     <= MID;
      restoring <= 1'b1;
      wp        <= 1'b0;
      err       <= 1'b0;
      nv_we     <= 1'b0;
      nv_wdata  <= '0;
      nv_view   <= '0;
    end else begin
      err   <= reject;
      nv_we <= acc_store;
      if (acc_store)  nv_wdata  <= wiper;
      if (op_start)   restoring <= acc_restore;
      if (acc_wp)     wp        <= 1'b1;
      if (acc_read)   nv_view   <= nv_rd_data;
      if (op_done && restoring) wiper <= nv_rd_data;
      else if (acc_write)       wiper <= cmd_data;
    end
  end

  p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
    nv_we |=> !nv_we);
  p_we_allowed_r6: assert property (@(posedge clk) disable iff (rst)
    nv_we |-> $past(!wp && !lock_active));
  p_wp_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    wp |=> wp);
  p_busy_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op_busy) |=> (err && !nv_we));
  p_undef_reject_r10: assert property (@(posedge clk) disable iff (rst)
    rej_undef |=> (err && $stable(wiper) && $stable(wp)));

endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
  import wnv_pkg::*;
#(
  parameter int POS_W       = 6,
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 12,
  parameter int REWRITE_CYC = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [POS_W-1:0] cmd_data,
  input  logic [POS_W-1:0] nv_rd_data,
  output logic [POS_W-1:0] wiper,
  output logic             busy,
  output logic             nv_lock,
  output logic             wp,
  output logic             err,
  output logic             nv_we,
  output logic [POS_W-1:0] nv_wdata,
  output logic [POS_W-1:0] nv_view
);

  localparam int OP_MAX = max2(STORE_CYC, RESTORE_CYC);
  localparam int CNT_W  = $clog2(OP_MAX + 1);
  localparam int LCK_W  = $clog2(REWRITE_CYC + 1);

  logic             op_start, op_done, lock_done;
  logic [CNT_W-1:0] op_load;

  // Shared store/restore window; loaded for a restore at power-on.
  wnv_timer #(.W(CNT_W)) u_op_tmr (
    .clk(clk), .rst(rst), .rst_load(CNT_W'(RESTORE_CYC - 1)),
    .start(op_start), .load(op_load), .active(busy), .done(op_done)
  );

  // Rewrite lockout, armed only by reset.
  wnv_timer #(.W(LCK_W)) u_lock_tmr (
    .clk(clk), .rst(rst), .rst_load(LCK_W'(REWRITE_CYC - 1)),
    .start(1'b0), .load('0), .active(nv_lock), .done(lock_done)
  );

  wnv_seq #(
    .POS_W(POS_W), .CNT_W(CNT_W),
    .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .nv_rd_data(nv_rd_data), .op_busy(busy),
    .op_done(op_done), .lock_active(nv_lock), .op_start(op_start),
    .op_load(op_load), .wiper(wiper), .nv_we(nv_we), .nv_wdata(nv_wdata),
    .nv_view(nv_view), .wp(wp), .err(err)
  );

  p_wiper_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> $stable(wiper));
  p_lock_over_r7: assert property (@(posedge clk) disable iff (rst)
    lock_done |=> !nv_lock);
  p_lock_no_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    !nv_lock |=> !nv_lock);
  p_store_starts_busy_r4: assert property (@(posedge clk) disable iff (rst)
    nv_we |-> busy);

endmodule

// File: tb/wiper_nv_ctrl_tb.sv
module wiper_nv_ctrl_tb;

  localparam int STORE_CYC   = 40;
  localparam int RESTORE_CYC = 12;
  localparam int REWRITE_CYC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [5:0] cmd_data = 6'd0;
  logic [5:0] nv_mem = 6'd0;
  logic       poke_en = 1'b0;
  logic [5:0] poke_val = 6'd0;
  logic [5:0] wiper, nv_wdata, nv_view;
  logic       busy, nv_lock, wp, err, nv_we;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Behavioural nonvolatile word.
  always @(posedge clk) begin
    if (poke_en)    nv_mem <= poke_val;
    else if (nv_we) nv_mem <= nv_wdata;
  end

  wiper_nv_ctrl #(
    .POS_W(6), .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC),
    .REWRITE_CYC(REWRITE_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .nv_rd_data(nv_mem), .wiper(wiper), .busy(busy),
    .nv_lock(nv_lock), .wp(wp), .err(err), .nv_we(nv_we),
    .nv_wdata(nv_wdata), .nv_view(nv_view)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [5:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 6'd0;
  endtask

  task automatic poke(input logic [5:0] v);
    poke_en = 1'b1; poke_val = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic t_power_on();
    rst = 1'b1;
    poke_en = 1'b1; poke_val = 6'h2D;
    repeat (3) @(negedge clk);
    poke_en = 1'b0;
    chk("R1", "wiper in reset", wiper, 6'h20);
    chk("R1", "busy in reset", busy, 1);
    chk("R1", "nv_lock in reset", nv_lock, 1);
    chk("R1", "wp/err/we in reset", {wp, err, nv_we}, 0);
    rst = 1'b0;
    repeat (RESTORE_CYC - 1) @(negedge clk);
    chk("R1", "midscale held", wiper, 6'h20);
    chk("R1", "busy held", busy, 1);
    @(negedge clk);
    chk("R2", "restored wiper", wiper, 6'h2D);
    chk("R2", "busy dropped", busy, 0);
  endtask

  task automatic t_lockout();
    // RESTORE_CYC cycles have elapsed since release.
    issue(3'd2, 6'd0);
    chk("R7", "store in lockout err", err, 1);
    chk("R7", "store in lockout we", nv_we, 0);
    repeat (REWRITE_CYC - 2 - RESTORE_CYC) @(negedge clk);
    chk("R7", "lock still on", nv_lock, 1);
    @(negedge clk);
    chk("R7", "lock released", nv_lock, 0);
    chk("R7", "memory untouched", nv_mem, 6'h2D);
  endtask

  task automatic t_write();
    issue(3'd1, 6'h11);
    chk("R3", "direct write", wiper, 6'h11);
    chk("R3", "no err", err, 0);
  endtask

  task automatic t_store();
    issue(3'd2, 6'd0);
    chk("R4", "we pulse", nv_we, 1);
    chk("R4", "write data", nv_wdata, 6'h11);
    chk("R4", "busy start", busy, 1);
    @(negedge clk);
    chk("R4", "we single", nv_we, 0);
    chk("R4", "memory written", nv_mem, 6'h11);
    issue(3'd1, 6'h3F);
    chk("R8", "write while busy err", err, 1);
    chk("R8", "wiper kept", wiper, 6'h11);
    repeat (STORE_CYC - 3) @(negedge clk);
    chk("R4", "busy last cycle", busy, 1);
    @(negedge clk);
    chk("R4", "busy end", busy, 0);
  endtask

  task automatic t_restore();
    issue(3'd1, 6'h07);
    poke(6'h2A);
    issue(3'd3, 6'd0);
    chk("R5", "busy start", busy, 1);
    chk("R5", "wiper before", wiper, 6'h07);
    repeat (RESTORE_CYC - 1) @(negedge clk);
    chk("R5", "wiper last busy", wiper, 6'h07);
    chk("R5", "busy last", busy, 1);
    @(negedge clk);
    chk("R5", "wiper loaded", wiper, 6'h2A);
    chk("R5", "busy end", busy, 0);
  endtask

  task automatic t_read_nv();
    poke(6'h15);
    issue(3'd5, 6'd0);
    chk("R9", "nv_view", nv_view, 6'h15);
  endtask

  task automatic t_protect();
    issue(3'd4, 6'd0);
    chk("R6", "wp armed", wp, 1);
    chk("R6", "no err", err, 0);
    issue(3'd1, 6'h33);
    chk("R3", "write under wp", wiper, 6'h33);
    issue(3'd2, 6'd0);
    chk("R6", "store err", err, 1);
    chk("R6", "store no we", nv_we, 0);
    chk("R6", "store no busy", busy, 0);
    @(negedge clk);
    chk("R6", "memory kept", nv_mem, 6'h15);
    chk("R6", "wp sticky", wp, 1);
  endtask

  task automatic t_undef();
    issue(3'd7, 6'h01);
    chk("R10", "undef err", err, 1);
    chk("R10", "undef wiper", wiper, 6'h33);
    issue(3'd6, 6'h02);
    chk("R10", "undef6 err", err, 1);
    issue(3'd0, 6'h03);
    chk("R10", "nop no err", err, 0);
    chk("R10", "nop wiper", wiper, 6'h33);
  endtask

  initial begin
    @(negedge clk);
    t_power_on();
    t_lockout();
    t_write();
    t_store();
    t_restore();
    t_read_nv();
    t_protect();
    t_undef();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule